// File: doc/BRIEF.md
# Half-Bridge Gate Pulse Generator

This block turns a requested half-period, given in clock cycles by a digital frequency source, into two complementary gate signals for a half-bridge, one for the low side and one for the high side. Each switching cycle has two halves of equal length. The low side owns the first half and the high side owns the second. Each half opens with a dead interval, during which both gates stay low, and the owning gate is high for the rest of that half. The two outputs therefore share a 50% duty cycle, minus the dead time, and a full cycle lasts exactly two half-periods.

A mode sequencer drives the enable input. When enable is removed, both gates drop. When enable is applied again, the block begins a fresh cycle on the low side at the fastest permitted rate. This gives the high-side bootstrap supply a charge before the high gate ever turns on. A select input chooses between a long and a short dead time. The block samples the half-period request and the dead-time select only where one full cycle ends, and it clamps the request into a fixed legal window. A one-cycle strobe marks each rising edge of the low-side gate, so that downstream current-sense logic can blank its input.

Top module: `hb_gate_gen`

## Requirements
- R1: While reset is asserted or enable is low, gate_lo, gate_hi and lo_rise are all 0.
- R2: After enable rises, the first gate pulse appears on gate_lo. gate_hi does not rise until gate_lo has been high since that enable.
- R3: The first full cycle after enable uses a half-period of HP_FAST cycles, whatever hp_req holds.
- R4: In each half-period of H cycles, both gates are low for the first D cycles, and the owning gate is then high for H-D cycles. The halves alternate low side first, then high side.
- R5: dt_sel = 0 selects a dead time of DT_LONG cycles, and dt_sel = 1 selects a dead time of DT_SHORT cycles.
- R6: A request below HP_FAST is treated as HP_FAST, and a request above HP_SLOW is treated as HP_SLOW.
- R7: hp_req and dt_sel are taken only when a high-side half ends. A change during a cycle leaves that cycle's low and high pulses unchanged.
- R8: gate_lo and gate_hi are never 1 in the same cycle.
- R9: lo_rise is 1 for exactly the one cycle in which gate_lo goes from 0 to 1, and it is 0 at every other time.
- R10: If enable is sampled low, both gates are 0 from the very next clock edge, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable from the mode sequencer |
| dt_sel | input | 1 | Dead-time select: 0 = long, 1 = short |
| hp_req | input | HP_W | Requested half-period in clock cycles |
| gate_lo | output | 1 | Low-side gate drive |
| gate_hi | output | 1 | High-side gate drive |
| lo_rise | output | 1 | One-cycle strobe on each gate_lo rising edge |

## Verification
The assertions make three assumptions about the inputs. The enable is synchronous to the clock. The parameters keep HP_FAST greater than DT_LONG. hp_req and dt_sel may change in any cycle without warning. The stimulus changes the request and the dead-time select only on the falling clock edge that follows a low-side strobe, which places every change in the middle of a cycle. This exposes any early pickup as a wrong pulse width. Enable is dropped both in the middle of a pulse and after the scoreboard has drained, so the blocking path is exercised from both sides.

// File: rtl/hb_gate_gen.sv
module hb_gate_gen #(
  parameter int HP_W      = 12,
  parameter int HP_FAST   = 40,
  parameter int HP_SLOW   = 400,
  parameter int DT_LONG   = 18,
  parameter int DT_SHORT  = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            dt_sel,
  input  logic [HP_W-1:0] hp_req,
  output logic            gate_lo,
  output logic            gate_hi,
  output logic            lo_rise
);

  localparam logic [HP_W-1:0] FAST_V  = HP_W'(HP_FAST);
  localparam logic [HP_W-1:0] SLOW_V  = HP_W'(HP_SLOW);
  localparam logic [HP_W-1:0] DTL_V   = HP_W'(DT_LONG);
  localparam logic [HP_W-1:0] DTS_V   = HP_W'(DT_SHORT);

  logic            run_q, run_n;
  logic            side_q, side_n;
  logic [HP_W-1:0] cnt_q, cnt_n;
  logic [HP_W-1:0] hp_q, hp_n;
  logic [HP_W-1:0] dt_q, dt_n;
  logic            lo_n, hi_n;

  wire [HP_W-1:0] hp_lim  = (hp_req < FAST_V) ? FAST_V :
                            (hp_req > SLOW_V) ? SLOW_V : hp_req;
  wire [HP_W-1:0] dt_pick = dt_sel ? DTS_V : DTL_V;
  wire            half_end = (cnt_q == hp_q - 1'b1);

  always_comb begin
    run_n  = run_q;
    side_n = side_q;
    cnt_n  = cnt_q;
    hp_n   = hp_q;
    dt_n   = dt_q;
    if (!en) begin
      run_n  = 1'b0;
      side_n = 1'b0;
      cnt_n  = '0;
    end else if (!run_q) begin
      run_n  = 1'b1;
      side_n = 1'b0;
      cnt_n  = '0;
      hp_n   = FAST_V;
      dt_n   = dt_pick;
    end else if (half_end) begin
      cnt_n  = '0;
      side_n = ~side_q;
      if (side_q) begin
        hp_n = hp_lim;
        dt_n = dt_pick;
      end
    end else begin
      cnt_n  = cnt_q + 1'b1;
    end
  end

  assign lo_n = run_n && !side_n && (cnt_n >= dt_n);
  assign hi_n = run_n &&  side_n && (cnt_n >= dt_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      side_q  <= 1'b0;
      cnt_q   <= '0;
      hp_q    <= FAST_V;
      dt_q    <= DTL_V;
      gate_lo <= 1'b0;
      gate_hi <= 1'b0;
      lo_rise <= 1'b0;
    end else begin
      run_q   <= run_n;
      side_q  <= side_n;
      cnt_q   <= cnt_n;
      hp_q    <= hp_n;
      dt_q    <= dt_n;
      gate_lo <= lo_n;
      gate_hi <= hi_n;
      lo_rise <= lo_n && !gate_lo;
    end
  end

endmodule

// File: rtl/hb_gate_gen_chk.sv
module hb_gate_gen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic gate_lo,
  input logic gate_hi,
  input logic lo_rise
);

  logic lo_seen;

  always_ff @(posedge clk) begin
    if (rst || !en) lo_seen <= 1'b0;
    else if (gate_lo) lo_seen <= 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!gate_lo && !gate_hi && !lo_rise));

  a_r2_low_first: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) |-> lo_seen);

  a_r4_dead_before_hi: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) |-> !$past(gate_lo));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(gate_lo && gate_hi));

  a_r9_strobe_edge: assert property (@(posedge clk) disable iff (rst)
    lo_rise |-> (gate_lo && !$past(gate_lo)));

  a_r10_disable_drop: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!gate_lo && !gate_hi));

endmodule

bind hb_gate_gen hb_gate_gen_chk u_chk (
  .clk(clk), .rst(rst), .en(en),
  .gate_lo(gate_lo), .gate_hi(gate_hi), .lo_rise(lo_rise)
);

// File: tb/hb_gate_gen_tb.sv
module hb_gate_gen_tb;

  localparam int W    = 12;
  localparam int FAST = 40;
  localparam int SLOW = 400;
  localparam int DTL  = 18;
  localparam int DTS  = 10;

  typedef struct packed {
    logic        side;
    logic [15:0] width;
    logic [15:0] dead;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic dt_sel = 1'b0;
  logic [W-1:0] hp_req = '0;
  logic gate_lo, gate_hi, lo_rise;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ign = 1'b1;
  item_t q[$];

  always #2.5 clk = ~clk;

  hb_gate_gen #(.HP_W(W), .HP_FAST(FAST), .HP_SLOW(SLOW),
                .DT_LONG(DTL), .DT_SHORT(DTS)) u_dut (
    .clk(clk), .rst(rst), .en(en), .dt_sel(dt_sel), .hp_req(hp_req),
    .gate_lo(gate_lo), .gate_hi(gate_hi), .lo_rise(lo_rise));

  function automatic int lim(int r);
    if (r < FAST) return FAST;
    if (r > SLOW) return SLOW;
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_cycle(int h, int d, bit first);
    item_t it;
    it.side = 1'b0; it.width = 16'(h - d); it.dead = first ? 16'hFFFF : 16'(d);
    q.push_back(it);
    it.side = 1'b1; it.width = 16'(h - d); it.dead = 16'(d);
    q.push_back(it);
  endtask

  task automatic wait_lo_rise();
    do @(negedge clk); while (!lo_rise);
  endtask

  task automatic step(int req, bit sel, int n);
    wait_lo_rise();
    hp_req = W'(req);
    dt_sel = sel;
    for (int i = 0; i < n; i++) push_cycle(lim(req), sel ? DTS : DTL, 1'b0);
    for (int i = 1; i < n; i++) wait_lo_rise();
  endtask

  task automatic drain();
    for (int i = 0; i < 5000 && q.size() != 0; i++) @(negedge clk);
    chk(q.size() == 0, "R4 scoreboard drained", q.size(), 0);
  endtask

  logic lo_p = 1'b0, hi_p = 1'b0;
  int gap = 0, wid = 0, rise_gap = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (gate_lo && gate_hi) chk(1'b0, "R8 overlap", 1, 0);
      if (gate_lo && !lo_p) chk(lo_rise === 1'b1, "R9 strobe on rise", lo_rise, 1);
      else if (lo_rise) chk(1'b0, "R9 stray strobe", 1, 0);
      if (gate_lo || gate_hi) begin
        if (!(lo_p || hi_p)) begin rise_gap = gap; wid = 1; end
        else wid++;
        gap = 0;
      end else begin
        if ((lo_p || hi_p) && !ign) begin
          if (q.size() == 0) chk(1'b0, "R4 unexpected pulse", wid, 0);
          else begin
            item_t e;
            e = q.pop_front();
            chk(hi_p == e.side, "R2/R4 pulse side", hi_p, e.side);
            chk(wid == int'(e.width), "R3/R4/R6/R7 pulse width", wid, e.width);
            if (e.dead != 16'hFFFF)
              chk(rise_gap == int'(e.dead), "R5 dead time", rise_gap, e.dead);
          end
        end
        gap++;
      end
      lo_p <= gate_lo;
      hi_p <= gate_hi;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "watchdog", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    hp_req = 12'd100;
    repeat (4) @(negedge clk);
    chk(!gate_lo && !gate_hi && !lo_rise, "R1 reset outputs low", gate_lo | gate_hi, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!gate_lo && !gate_hi, "R1 disabled outputs low", gate_lo | gate_hi, 0);

    ign = 1'b0;
    dt_sel = 1'b0;
    push_cycle(FAST, DTL, 1'b1);
    en = 1'b1;
    step(100, 1'b0, 2);
    step(20, 1'b1, 2);
    step(1000, 1'b0, 1);
    step(60, 1'b1, 3);
    wait_lo_rise();
    repeat (7) @(negedge clk);
    ign = 1'b1;
    en = 1'b0;
    @(negedge clk);
    chk(!gate_lo && !gate_hi, "R10 drop mid pulse", gate_lo, 0);
    repeat (20) @(negedge clk);
    chk(!gate_lo && !gate_hi && !lo_rise, "R1 held low while disabled", gate_lo | gate_hi, 0);

    q.delete();
    ign = 1'b0;
    hp_req = 12'd300;
    dt_sel = 1'b1;
    push_cycle(FAST, DTS, 1'b1);
    en = 1'b1;
    step(50, 1'b0, 2);
    drain();
    ign = 1'b1;
    en = 1'b0;
    @(negedge clk);
    chk(!gate_lo && !gate_hi, "R10 drop after drain", gate_hi, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule